// File: doc/BRIEF.md
# Shared Free-Running Counter with Per-Core Compare Timers

This block holds one free-running count that several cores share, and it gives each core its own compare register and its own timer interrupt line. Software starts the count by clearing a stop bit. It reads the count either as one 64-bit word or as two 32-bit halves. To arm a core's timer, software writes a future count value into that core's compare register. When the count steps onto that value, the core's interrupt goes pending. It stays pending until software writes the compare register again, and that write is the acknowledge.

All accesses travel on one simple request port that carries the index of the requesting core. Each core sees the same small register window. The local compare slot always reaches the requester's own compare register. A redirected compare slot reaches the compare register of whichever core the requester last wrote into its own selector slot. The count is 32 + 4·`WIDTH_CODE` bits wide. The width code can be read from a configuration word, and every bit above the width reads as zero.

Top module: `shared_count_timer`

## Requirements
- R1: A read of the configuration word (address 0) returns `WIDTH_CODE` in bits [3:0]. The count width is 32 + 4·`WIDTH_CODE`. Writing bits [3:0] of the configuration word has no effect on them.
- R2: After reset the stop bit (configuration bit 8) reads 1, every timer interrupt is low, and the count reads zero and holds at zero.
- R3: While the stop bit is 0, the count rises by exactly one per clock. Writing bit 8 to 1 freezes the count at its present value.
- R4: Address 1 returns the whole count, zero-extended to 64 bits. Address 2 returns count bits [31:0]. Address 3 returns count bits [63:32] in rdata[31:0]. Unused rdata bits read 0.
- R5: While stopped, a write to address 1 loads the whole count, a write to address 2 replaces only bits [31:0], and a write to address 3 replaces only bits [63:32] from wdata[31:0]. Bits beyond the width are dropped. While counting, writes to these addresses are ignored.
- R6: After the count reaches its all-ones value, it continues at zero.
- R7: Address 4 reads and writes the compare register of the requesting core. Address 5 holds that core's selector (a core index). Compare values keep only the counter width.
- R8: Address 6 reads and writes the compare register of the core named by the requester's own selector.
- R9: A core's interrupt goes high on the same cycle that the count first reads equal to its compare value. It stays high while no write reaches that compare register.
- R10: Any write to a core's compare register, through either slot and even with an unchanged value, clears that core's interrupt.
- R11: A compare value that the count has already passed raises no interrupt until the count wraps around and reaches it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_core | input | CW | Index of the requesting core |
| req_addr | input | 4 | Register slot |
| req_wdata | input | 64 | Write data |
| rsp_rdata | output | 64 | Read data for the current read request (combinational) |
| timer_irq | output | NUM_CORES | Pending timer interrupt, one per core |

## Verification
The assertions take for granted that each request names a core index below `NUM_CORES` and that every selector holds an existing core. They also assume that a compare write never lands on the cycle in which that core's match arrives. If it does, the write wins and the match is lost. The stimulus writes only in-range indices into the selectors. It arms every compare value hundreds of counts ahead of the running counter, or while the counter is stopped, so no acknowledge and match ever coincide.

// File: rtl/sct_pkg.sv
package sct_pkg;

  typedef enum logic [3:0] {
    A_CFG  = 4'h0,
    A_CNT  = 4'h1,
    A_LO   = 4'h2,
    A_HI   = 4'h3,
    A_LCMP = 4'h4,
    A_LSEL = 4'h5,
    A_OCMP = 4'h6
  } sct_addr_e;

  localparam int STOP_BIT = 8;

  // Counter width in bits for a given width code.
  function automatic int cnt_width(input int code);
    return 32 + 4 * code;
  endfunction

  // Configuration word as seen on a read.
  function automatic logic [63:0] cfg_word(input logic [3:0] code, input logic stop);
    logic [63:0] w;
    w = '0;
    w[3:0] = code;
    w[STOP_BIT] = stop;
    return w;
  endfunction

  // New 64-bit count image after a load through one of the count slots.
  function automatic logic [63:0] merge_count(input logic [63:0] cur,
                                              input logic [63:0] wd,
                                              input logic [3:0]  addr);
    logic [63:0] r;
    case (addr)
      A_LO:    r = {cur[63:32], wd[31:0]};
      A_HI:    r = {wd[31:0], cur[31:0]};
      default: r = wd;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sct_counter.sv
module sct_counter #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stop_we,
  input  logic         stop_wdata,
  input  logic         load_req,
  input  logic [3:0]   load_addr,
  input  logic [63:0]  load_wdata,
  output logic [W-1:0] count_q,
  output logic [W-1:0] count_next,
  output logic         stop_q,
  output logic         step
);
  import sct_pkg::*;

  logic         load;
  logic [63:0]  load_img;

  assign step       = !stop_q;
  assign count_next = count_q + W'(1);
  assign load       = stop_q && load_req;
  assign load_img   = merge_count(64'(count_q), load_wdata, load_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      stop_q  <= 1'b1;
    end else begin
      if (stop_we) stop_q <= stop_wdata;
      if (load)       count_q <= load_img[W-1:0];
      else if (step)  count_q <= count_next;
    end
  end

  // R3: a stopped count without a load keeps its value
  p_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !load_req) |=> (count_q == $past(count_q)));

  // R3/R6: a running count advances by one, wrapping at the width
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_q) |=> (count_q == W'($past(count_q) + W'(1))));

  // R5: count slots are ignored while running
  p_noload_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_q && load_req) |=> (count_q == W'($past(count_q) + W'(1))));

endmodule

// File: rtl/sct_cmp_slot.sv
module sct_cmp_slot #(
  parameter int W  = 40,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_we,
  input  logic [W-1:0]  cmp_wdata,
  input  logic          sel_we,
  input  logic [CW-1:0] sel_wdata,
  input  logic          step,
  input  logic [W-1:0]  count_next,
  output logic [W-1:0]  cmp_q,
  output logic [CW-1:0] sel_q,
  output logic          pend_q,
  output logic          hit
);

  // match event: the counter is about to step onto the compare value
  assign hit = step && (count_next == cmp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      sel_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (cmp_we) cmp_q <= cmp_wdata;
      if (sel_we) sel_q <= sel_wdata;
      if (cmp_we)    pend_q <= 1'b0;
      else if (hit)  pend_q <= 1'b1;
    end
  end

  // R10: any compare write acknowledges
  p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we |=> !pend_q);

  // R9: a match raises the interrupt
  p_hit_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !cmp_we) |=> pend_q);

  // R9: pending holds until a compare write
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !cmp_we) |=> pend_q);

  // R11: no interrupt without a match event
  p_no_spurious_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !hit) |=> !pend_q);

endmodule

// File: rtl/shared_count_timer.sv
module shared_count_timer #(
  parameter int  NUM_CORES  = 4,
  parameter int  WIDTH_CODE = 2,
  localparam int CW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [CW-1:0]        req_core,
  input  logic [3:0]           req_addr,
  input  logic [63:0]          req_wdata,
  output logic [63:0]          rsp_rdata,
  output logic [NUM_CORES-1:0] timer_irq
);
  import sct_pkg::*;

  localparam int W = cnt_width(WIDTH_CODE);
  localparam logic [3:0] CODE = 4'(WIDTH_CODE);

  logic                 wr;
  logic [W-1:0]         count_q, count_next;
  logic                 stop_q, step;
  logic [63:0]          count_ext;
  logic [W-1:0]         cmp_arr [NUM_CORES];
  logic [CW-1:0]        sel_arr [NUM_CORES];
  logic [NUM_CORES-1:0] cmp_we, sel_we, hit_vec;
  logic [W-1:0]         own_cmp, oth_cmp;
  logic [CW-1:0]        own_sel;

  assign wr        = req_valid && req_write;
  assign count_ext = 64'(count_q);

  sct_counter #(.W(W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_we    (wr && (req_addr == A_CFG)),
    .stop_wdata (req_wdata[STOP_BIT]),
    .load_req   (wr && ((req_addr == A_CNT) || (req_addr == A_LO) || (req_addr == A_HI))),
    .load_addr  (req_addr),
    .load_wdata (req_wdata),
    .count_q    (count_q),
    .count_next (count_next),
    .stop_q     (stop_q),
    .step       (step)
  );

  // requester's own slot, and the slot its selector names
  always_comb begin
    own_cmp = '0;
    own_sel = '0;
    oth_cmp = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (CW'(i) == req_core) begin
        own_cmp = cmp_arr[i];
        own_sel = sel_arr[i];
      end
    end
    for (int i = 0; i < NUM_CORES; i++) begin
      if (CW'(i) == own_sel) oth_cmp = cmp_arr[i];
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_CORES; i++) begin
      cmp_we[i] = wr && (((req_addr == A_LCMP) && (req_core == CW'(i))) ||
                         ((req_addr == A_OCMP) && (own_sel  == CW'(i))));
      sel_we[i] = wr && (req_addr == A_LSEL) && (req_core == CW'(i));
    end
  end

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_slot
    sct_cmp_slot #(.W(W), .CW(CW)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmp_we     (cmp_we[g]),
      .cmp_wdata  (req_wdata[W-1:0]),
      .sel_we     (sel_we[g]),
      .sel_wdata  (req_wdata[CW-1:0]),
      .step       (step),
      .count_next (count_next),
      .cmp_q      (cmp_arr[g]),
      .sel_q      (sel_arr[g]),
      .pend_q     (timer_irq[g]),
      .hit        (hit_vec[g])
    );
  end

  always_comb begin
    rsp_rdata = '0;
    if (req_valid && !req_write) begin
      case (req_addr)
        A_CFG:   rsp_rdata = cfg_word(CODE, stop_q);
        A_CNT:   rsp_rdata = count_ext;
        A_LO:    rsp_rdata = {32'h0, count_ext[31:0]};
        A_HI:    rsp_rdata = {32'h0, count_ext[63:32]};
        A_LCMP:  rsp_rdata = 64'(own_cmp);
        A_LSEL:  rsp_rdata = 64'(own_sel);
        A_OCMP:  rsp_rdata = 64'(oth_cmp);
        default: rsp_rdata = '0;
      endcase
    end
  end

  // R1: configuration read reports the width code
  p_cfg_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && (req_addr == A_CFG)) |-> (rsp_rdata[3:0] == CODE));

  // R10: one write acknowledges at most one core
  p_single_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cmp_we) <= 1);

  // R9: matches happen only while counting
  p_hit_running_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec != '0) |-> !stop_q);

endmodule

// File: tb/shared_count_timer_bench.sv
module shared_count_timer_bench;

  localparam int NC   = 4;
  localparam int CODE = 2;
  localparam int WID  = 32 + 4 * CODE;
  localparam logic [63:0] WMAX = (64'd1 << WID) - 64'd1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_core = '0;
  logic [3:0]  req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [63:0] rsp_rdata;
  logic [NC-1:0] timer_irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  shared_count_timer #(.NUM_CORES(NC), .WIDTH_CODE(CODE)) u_shared_count_timer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_core(req_core), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .timer_irq(timer_irq)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [1:0]  core;
    logic [3:0]  addr;
    logic        wr;
    logic [63:0] wdata;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{4'd1, 2'd0, 4'h0, 1'b0, 64'h0, 64'h102},                    // R1 R2 code 2, stop 1
    '{4'd2, 2'd1, 4'h1, 1'b0, 64'h0, 64'h0},                      // R2 count zero
    '{4'd5, 2'd0, 4'h1, 1'b1, 64'hFFFF_1234_5678_9ABC, 64'h0},    // R5 full load
    '{4'd4, 2'd2, 4'h1, 1'b0, 64'h0, 64'h34_5678_9ABC},           // R4 full read
    '{4'd4, 2'd0, 4'h2, 1'b0, 64'h0, 64'h5678_9ABC},              // R4 low half
    '{4'd4, 2'd0, 4'h3, 1'b0, 64'h0, 64'h34},                     // R4 high half
    '{4'd5, 2'd1, 4'h2, 1'b1, 64'hFFFF_FFFF_DEAD_BEEF, 64'h0},    // R5 low load
    '{4'd5, 2'd0, 4'h1, 1'b0, 64'h0, 64'h34_DEAD_BEEF},
    '{4'd5, 2'd0, 4'h3, 1'b1, 64'h1AB, 64'h0},                    // R5 high load
    '{4'd5, 2'd0, 4'h1, 1'b0, 64'h0, 64'hAB_DEAD_BEEF},
    '{4'd1, 2'd0, 4'h0, 1'b1, 64'h10F, 64'h0},                    // R1 code write
    '{4'd1, 2'd0, 4'h0, 1'b0, 64'h0, 64'h102},
    '{4'd7, 2'd1, 4'h4, 1'b1, 64'h100, 64'h0},                    // R7 local compare
    '{4'd7, 2'd1, 4'h4, 1'b0, 64'h0, 64'h100},
    '{4'd7, 2'd0, 4'h4, 1'b0, 64'h0, 64'h0},
    '{4'd7, 2'd0, 4'h5, 1'b1, 64'h3, 64'h0},                      // R7 selector
    '{4'd7, 2'd0, 4'h5, 1'b0, 64'h0, 64'h3},
    '{4'd8, 2'd0, 4'h6, 1'b1, 64'h777, 64'h0},                    // R8 other window
    '{4'd8, 2'd3, 4'h4, 1'b0, 64'h0, 64'h777},
    '{4'd8, 2'd0, 4'h6, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},    // R8 R7 masked
    '{4'd8, 2'd3, 4'h4, 1'b0, 64'h0, 64'hFF_FFFF_FFFF},
    '{4'd8, 2'd3, 4'h6, 1'b0, 64'h0, 64'h0}                       // R8 selector 0
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] c, input logic [3:0] a, input logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_core = c; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] c, input logic [3:0] a, output logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_core = c; req_addr = a;
    #1;
    d = rsp_rdata;
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %h expected %h", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    logic [63:0] v, prev, v1, v2, expv;
    bit found;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2: reset state, count held
    #1;
    check(timer_irq == '0, "R2 irq after reset", 64'(timer_irq), 64'h0);
    repeat (4) @(negedge clk);
    bus_rd(2'd0, 4'h1, v);
    check(v == 64'h0, "R2 count held at zero", v, 64'h0);

    // table of register accesses while stopped
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) begin
        bus_wr(VECS[i].core, VECS[i].addr, VECS[i].wdata);
      end else begin
        bus_rd(VECS[i].core, VECS[i].addr, v);
        check(v == VECS[i].exp, $sformatf("R%0d table row %0d", VECS[i].req, i), v, VECS[i].exp);
      end
    end
    #1;
    check(timer_irq == '0, "R9 no irq while stopped", 64'(timer_irq), 64'h0);

    // arm compares, start counting
    bus_wr(2'd0, 4'h1, 64'd100);
    bus_wr(2'd2, 4'h4, 64'd110);
    bus_wr(2'd0, 4'h6, 64'h200);      // core3 via selector 3
    bus_wr(2'd1, 4'h4, 64'h1000);
    bus_wr(2'd0, 4'h0, 64'h0);        // clear stop

    // R3 step by one, R9 irq on match
    prev = 64'd100;
    for (int k = 0; k < 15; k++) begin
      bus_rd(2'd2, 4'h1, v);
      check(v == prev + 64'd1, "R3 count steps by one", v, prev + 64'd1);
      check(timer_irq[2] == (v >= 64'd110), "R9 irq follows match", 64'(timer_irq[2]),
            64'(v >= 64'd110));
      prev = v;
    end

    // R10 acknowledge with unchanged value; R11 passed compare stays quiet
    bus_wr(2'd2, 4'h4, 64'd110);
    for (int k = 0; k < 3; k++) begin
      bus_rd(2'd2, 4'h1, v);
      check(timer_irq[2] == 1'b0, "R10 R11 irq cleared and quiet", 64'(timer_irq[2]), 64'h0);
    end

    // R5 count load ignored while running
    bus_rd(2'd0, 4'h1, v1);
    bus_wr(2'd0, 4'h1, 64'h0);
    bus_rd(2'd0, 4'h1, v2);
    check(v2 == v1 + 64'd3, "R5 load ignored while running", v2, v1 + 64'd3);

    // R9 core3 match, R10 acknowledge through the other window
    found = 1'b0;
    for (int k = 0; k < 2000 && !found; k++) begin
      bus_rd(2'd3, 4'h1, v);
      if (timer_irq[3]) found = 1'b1;
    end
    check(found && v == 64'h200, "R9 irq rises at compare", v, 64'h200);
    bus_wr(2'd0, 4'h6, 64'h200);
    bus_rd(2'd0, 4'h1, v);
    check(timer_irq[3] == 1'b0, "R10 ack through other window", 64'(timer_irq[3]), 64'h0);
    check(timer_irq[1] == 1'b0, "R9 far compare not raised", 64'(timer_irq[1]), 64'h0);

    // R3 freeze
    bus_wr(2'd0, 4'h0, 64'h100);
    bus_rd(2'd0, 4'h1, v1);
    repeat (4) @(negedge clk);
    bus_rd(2'd0, 4'h1, v2);
    check(v1 == v2, "R3 freeze on stop", v2, v1);
    bus_rd(2'd0, 4'h0, v);
    check(v == 64'h102, "R1 R3 config with stop set", v, 64'h102);

    // R6 wrap, R11 past compare fires only after wrap
    bus_wr(2'd0, 4'h1, WMAX - 64'd2);
    bus_wr(2'd0, 4'h4, 64'd2);
    bus_wr(2'd0, 4'h0, 64'h0);
    expv = WMAX - 64'd2;
    for (int k = 0; k < 8; k++) begin
      expv = (expv + 64'd1) & WMAX;
      bus_rd(2'd0, 4'h1, v);
      check(v == expv, "R6 count wraps", v, expv);
      check(timer_irq[0] == (expv >= 64'd2 && expv < 64'd100), "R11 past compare waits for wrap",
            64'(timer_irq[0]), 64'(expv >= 64'd2 && expv < 64'd100));
    end

    finish_run();
  end

endmodule